// File: doc/BRIEF.md
# Four-Way Zero-Wait Bus Slave Memory Subsystem

This block puts four small on-chip memories on a pipelined system bus. The two most significant address bits pick the slave. Each slave has a front end that turns the bus transfer signals into a chip-select and a read/write-select for its memory. Those two signals are registered, so they are valid in the data phase that follows each address phase.

Every transfer completes in one data-phase cycle. The ready output stays high at all times after reset, and the response output always reports OKAY. Single transfers are supported, and so are incrementing bursts of undefined length. A burst is tracked per slave by an explicit read-burst or write-burst state. Sequential beats then keep the direction that the opening beat set, whatever the write and burst-type inputs say.

Read data from the four slaves is merged by a 4-to-1 multiplexer. The multiplexer is steered by the decoded select vector, which is registered on each active address phase.

Top module: `ahb_mem_subsys`

## Requirements
- R1: While `rst` is high at a clock edge, all `slv_cs` and `slv_rws` bits and `hready` are low after that edge. An open burst is also cleared, so a sequential beat (`htrans`=2'b11) right after reset is not served.
- R2: Address bits [7:6] select the slave one-hot (00→slave 0, 01→1, 10→2, 11→3). The data phase raises only that slave's bit of `slv_cs`, and at most one `slv_cs` bit is ever high.
- R3: A non-sequential transfer (`htrans`=2'b10) with burst type single (`hburst`=3'b000) raises the addressed slave's `slv_cs` in the following cycle. In that same cycle, `slv_rws` of that slave equals the `hwrite` sampled in the address phase (1 = write).
- R4: A non-sequential transfer with burst type incrementing (`hburst`=3'b001) opens a read or write burst, following `hwrite`. Each sequential beat (`htrans`=2'b11) in the burst is then served with the opening direction, and the `hwrite` and `hburst` values on those beats have no effect. A busy cycle (`htrans`=2'b01) inside a burst serves nothing and keeps the burst open.
- R5: An idle transfer (`htrans`=2'b00) during a burst closes it. `slv_cs` is low in the next cycle, and a later sequential beat is not served.
- R6: In the data phase of a write, `hwdata` is stored at word index `haddr`[5:2] of the selected slave, using the address captured in the address phase. This includes a write that is directly followed by a read of the same word.
- R7: In the data phase of a read, `hrdata` equals the word last written at the captured index of the selected slave.
- R8: Idle transfers, busy transfers and sequential beats that fall outside a burst leave every `slv_cs` low and change no memory word.
- R9: After reset, `hready` is high in every cycle and `hresp` is always 0 (OKAY).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| haddr | input | 8 | Byte address: [7:6] slave, [5:2] word index |
| htrans | input | 2 | Transfer type: 00 idle, 01 busy, 10 non-sequential, 11 sequential |
| hwrite | input | 1 | 1 = write, 0 = read |
| hburst | input | 3 | Burst type: 000 single, 001 incrementing |
| hwdata | input | 32 | Write data, driven in the data phase |
| hrdata | output | 32 | Read data, valid in the data phase of a read |
| hready | output | 1 | Transfer done; high in every cycle after reset |
| hresp | output | 1 | Response, always OKAY (0) |
| slv_cs | output | 4 | Per-slave data-phase chip-select |
| slv_rws | output | 4 | Per-slave data-phase read/write-select (1 = write) |

## Verification
The bench uses the default configuration of four slaves with sixteen 32-bit words each. This makes all 64 storage locations small enough to write and read back one by one, so every decode value and every word index is covered. Expected data is computed arithmetically from the slave and index numbers. The same small size lets each burst cross many words of one slave. Inside those bursts the bench flips the ignored write and burst-type inputs, inserts busy cycles, sends sequential beats after a burst has closed, and applies a reset in the middle of a burst. A final full read-back then confirms that none of these disturbed memory.

// File: rtl/ahb_mem_pkg.sv
package ahb_mem_pkg;

  // Transfer type codes
  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_BUSY = 2'b01;
  localparam logic [1:0] TR_NSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ  = 2'b11;

  // Burst type codes
  localparam logic [2:0] BT_SINGLE = 3'b000;
  localparam logic [2:0] BT_INCR   = 3'b001;

  // Response code
  localparam logic RESP_OKAY = 1'b0;

  // Per-slave front-end state
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_RD_BURST = 2'd1,
    ST_WR_BURST = 2'd2
  } slv_state_e;

  // Data-phase control bundle
  typedef struct packed {
    logic cs;
    logic rws;
  } dp_ctl_t;

endpackage

// File: rtl/ahb_addr_dec.sv
module ahb_addr_dec #(
  parameter int ADDR_W  = 8,
  parameter int NUM_SLV = 4
) (
  input  logic [ADDR_W-1:0]  haddr,
  output logic [NUM_SLV-1:0] sel_vec
);
  localparam int SEL_W = $clog2(NUM_SLV);

  logic [SEL_W-1:0] region;
  assign region = haddr[ADDR_W-1 -: SEL_W];

  for (genvar g = 0; g < NUM_SLV; g++) begin : g_sel
    assign sel_vec[g] = (region == SEL_W'(g));
  end

endmodule

// File: rtl/ahb_slv_ctrl.sv
module ahb_slv_ctrl
  import ahb_mem_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsel,
  input  logic [1:0]       htrans,
  input  logic             hwrite,
  input  logic [2:0]       hburst,
  input  logic [IDX_W-1:0] idx_in,
  output logic             cs_o,
  output logic             rws_o,
  output logic             rdy_o,
  output logic [IDX_W-1:0] idx_o
);

  slv_state_e state_q, state_d;
  dp_ctl_t    ctl_q, ctl_d;
  logic       rdy_q;
  logic [IDX_W-1:0] idx_q;
  logic       in_burst;

  assign in_burst = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    ctl_d   = '0;
    if (in_burst && htrans == TR_SEQ) begin
      ctl_d.cs  = 1'b1;
      ctl_d.rws = (state_q == ST_WR_BURST);
    end else if (in_burst && htrans == TR_BUSY) begin
      state_d = state_q;
    end else begin
      state_d = ST_IDLE;
      if (hsel && htrans == TR_NSEQ) begin
        ctl_d.cs  = 1'b1;
        ctl_d.rws = hwrite;
        if (hburst == BT_INCR) begin
          state_d = hwrite ? ST_WR_BURST : ST_RD_BURST;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ctl_q   <= '0;
      rdy_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      ctl_q   <= ctl_d;
      rdy_q   <= 1'b1;
      if (ctl_d.cs) begin
        idx_q <= idx_in;
      end
    end
  end

  assign cs_o  = ctl_q.cs;
  assign rws_o = ctl_q.rws;
  assign rdy_o = rdy_q;
  assign idx_o = idx_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!ctl_q.cs && !ctl_q.rws && !rdy_q && state_q == ST_IDLE));

  // R3
  single_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && hsel && htrans == TR_NSEQ && hburst == BT_SINGLE)
    |=> (ctl_q.cs && ctl_q.rws == $past(hwrite) && state_q == ST_IDLE));

  // R4
  wr_burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WR_BURST && htrans == TR_SEQ)
    |=> (ctl_q.cs && ctl_q.rws && state_q == ST_WR_BURST));

  // R4
  rd_burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RD_BURST && htrans == TR_SEQ)
    |=> (ctl_q.cs && !ctl_q.rws && state_q == ST_RD_BURST));

  // R5
  burst_end_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && htrans == TR_IDLE)
    |=> (!ctl_q.cs && state_q == ST_IDLE));

endmodule

// File: rtl/ahb_slv_mem.sv
module ahb_slv_mem #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 16
) (
  input  logic                     clk,
  input  logic                     cs,
  input  logic                     rws,
  input  logic [$clog2(WORDS)-1:0] idx,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata
);

  logic [DATA_W-1:0] mem [WORDS];
  logic              wr_en;
  logic              rd_en;

  assign wr_en = cs && rws;
  assign rd_en = cs && !rws;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = rd_en ? mem[idx] : '0;

endmodule

// File: rtl/ahb_rd_mux.sv
module ahb_rd_mux #(
  parameter int DATA_W  = 32,
  parameter int NUM_SLV = 4
) (
  input  logic [NUM_SLV-1:0]             sel,
  input  logic [NUM_SLV-1:0][DATA_W-1:0] rd_in,
  output logic [DATA_W-1:0]              rd_out
);

  always_comb begin
    rd_out = '0;
    for (int i = 0; i < NUM_SLV; i++) begin
      if (sel[i]) begin
        rd_out = rd_out | rd_in[i];
      end
    end
  end

endmodule

// File: rtl/ahb_mem_subsys.sv
module ahb_mem_subsys
  import ahb_mem_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int WORDS   = 16,
  parameter int NUM_SLV = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  haddr,
  input  logic [1:0]         htrans,
  input  logic               hwrite,
  input  logic [2:0]         hburst,
  input  logic [DATA_W-1:0]  hwdata,
  output logic [DATA_W-1:0]  hrdata,
  output logic               hready,
  output logic               hresp,
  output logic [NUM_SLV-1:0] slv_cs,
  output logic [NUM_SLV-1:0] slv_rws
);

  localparam int SEL_W = $clog2(NUM_SLV);
  localparam int IDX_W = $clog2(WORDS);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic [NUM_SLV-1:0]             hsel_vec;
  logic [NUM_SLV-1:0]             dsel_q;
  logic [NUM_SLV-1:0]             rdy_vec;
  logic [NUM_SLV-1:0][DATA_W-1:0] rd_vec;
  logic [IDX_W-1:0]               idx_in;
  logic                           unused_addr_bits;

  assign idx_in           = haddr[IDX_HI:IDX_LO];
  assign unused_addr_bits = ^haddr[IDX_LO-1:0];

  ahb_addr_dec #(
    .ADDR_W  (ADDR_W),
    .NUM_SLV (NUM_SLV)
  ) u_dec (
    .haddr   (haddr),
    .sel_vec (hsel_vec)
  );

  // Data-phase steering of the read multiplexer
  always_ff @(posedge clk) begin
    if (rst) begin
      dsel_q <= '0;
    end else if (htrans[1]) begin
      dsel_q <= hsel_vec;
    end
  end

  for (genvar s = 0; s < NUM_SLV; s++) begin : g_slv
    logic [IDX_W-1:0] idx_s;

    ahb_slv_ctrl #(
      .IDX_W (IDX_W)
    ) u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .hsel   (hsel_vec[s]),
      .htrans (htrans),
      .hwrite (hwrite),
      .hburst (hburst),
      .idx_in (idx_in),
      .cs_o   (slv_cs[s]),
      .rws_o  (slv_rws[s]),
      .rdy_o  (rdy_vec[s]),
      .idx_o  (idx_s)
    );

    ahb_slv_mem #(
      .DATA_W (DATA_W),
      .WORDS  (WORDS)
    ) u_mem (
      .clk   (clk),
      .cs    (slv_cs[s]),
      .rws   (slv_rws[s]),
      .idx   (idx_s),
      .wdata (hwdata),
      .rdata (rd_vec[s])
    );
  end

  ahb_rd_mux #(
    .DATA_W  (DATA_W),
    .NUM_SLV (NUM_SLV)
  ) u_mux (
    .sel    (dsel_q),
    .rd_in  (rd_vec),
    .rd_out (hrdata)
  );

  assign hready = &rdy_vec;
  assign hresp  = RESP_OKAY;

  // R2
  one_slave_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slv_cs));

  // R9
  ready_high_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (hready && hresp == RESP_OKAY));

  // R8
  idle_no_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (htrans == TR_IDLE) |=> (slv_cs == '0));

  initial begin
    assert (ADDR_W >= SEL_W + IDX_W + IDX_LO)
      else $error("address too narrow for decode and index fields");
  end

endmodule

// File: tb/tb_ahb_mem_subsys.sv
module tb_ahb_mem_subsys;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int WD = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic [2:0]  hburst = 3'b000;
  logic [31:0] hwdata = '0;
  logic [31:0] hrdata;
  logic        hready;
  logic        hresp;
  logic [3:0]  slv_cs;
  logic [3:0]  slv_rws;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] exp_mem [NS][WD];

  // model of the pending data phase
  bit          p_act = 0;
  bit          p_wr = 0;
  int          p_sl = 0;
  int          p_ix = 0;
  logic [31:0] p_wd = '0;
  string       p_tag = "";
  int          bst = 0;
  int          bsl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ahb_mem_subsys dut (
    .clk     (clk),
    .rst     (rst),
    .haddr   (haddr),
    .htrans  (htrans),
    .hwrite  (hwrite),
    .hburst  (hburst),
    .hwdata  (hwdata),
    .hrdata  (hrdata),
    .hready  (hready),
    .hresp   (hresp),
    .slv_cs  (slv_cs),
    .slv_rws (slv_rws)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input int s, input int i);
    return 8'((s << 6) | (i << 2));
  endfunction

  function automatic logic [31:0] pat(input int s, input int i, input int salt);
    return 32'h5A00_0000 ^ (32'(s) * 32'h0011_0000) ^ (32'(i) * 32'h0000_0101) ^ 32'(salt);
  endfunction

  task automatic cyc(input logic [7:0] a, input logic [1:0] t, input logic w,
                     input logic [2:0] b, input logic [31:0] wd, input string tag);
    logic [3:0] exp_cs;
    logic [3:0] exp_rws;
    @(negedge clk);
    exp_cs  = p_act ? (4'b0001 << p_sl) : 4'b0000;
    exp_rws = (p_act && p_wr) ? exp_cs : 4'b0000;
    chk(slv_cs == exp_cs, {p_tag, " chip-select"}, 32'(slv_cs), 32'(exp_cs));
    chk(slv_rws == exp_rws, {p_tag, " read/write-select"}, 32'(slv_rws), 32'(exp_rws));
    chk(hready === 1'b1 && hresp === 1'b0, "R9 ready high, response okay",
        {30'd0, hready, hresp}, 32'h2);
    if (p_act && !p_wr) begin
      chk(hrdata === exp_mem[p_sl][p_ix], {p_tag, " read data"}, hrdata, exp_mem[p_sl][p_ix]);
    end
    // data phase of the previous transfer
    hwdata = p_wd;
    if (p_act && p_wr) exp_mem[p_sl][p_ix] = p_wd;
    // address phase of this transfer
    haddr = a; htrans = t; hwrite = w; hburst = b;
    p_wd = wd;
    p_tag = tag;
    if (bst != 0 && t == 2'b11) begin
      p_act = 1; p_wr = (bst == 2); p_sl = bsl; p_ix = int'(a[5:2]);
    end else if (bst != 0 && t == 2'b01) begin
      p_act = 0;
    end else begin
      bst = 0;
      p_act = 0;
      if (t == 2'b10) begin
        p_act = 1; p_wr = w; p_sl = int'(a[7:6]); p_ix = int'(a[5:2]);
        if (b == 3'b001) begin
          bst = w ? 2 : 1;
          bsl = p_sl;
        end
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    hwdata = p_wd;
    if (p_act && p_wr) exp_mem[p_sl][p_ix] = p_wd;
    rst = 1'b1; htrans = 2'b00;
    p_act = 0; bst = 0;
    repeat (2) @(negedge clk);
    chk(slv_cs == 4'b0, "R1 reset chip-select", 32'(slv_cs), 32'h0);
    chk(slv_rws == 4'b0, "R1 reset read/write-select", 32'(slv_rws), 32'h0);
    chk(hready == 1'b0, "R1 reset ready low", 32'(hready), 32'h0);
    chk(hresp == 1'b0, "R9 response okay in reset", 32'(hresp), 32'h0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();

    // R2 R3 R6: single write of every word in every slave
    for (int s = 0; s < NS; s++) begin
      for (int i = 0; i < WD; i++) begin
        cyc(mk(s, i), 2'b10, 1'b1, 3'b000, pat(s, i, 0), "R2 R3 R6 single write");
      end
    end
    cyc(8'h00, 2'b00, 1'b0, 3'b000, 32'hDEAD_BEEF, "R8 idle");

    // R2 R7: single read of every word
    for (int s = 0; s < NS; s++) begin
      for (int i = 0; i < WD; i++) begin
        cyc(mk(s, i), 2'b10, 1'b0, 3'b000, 32'h0, "R2 R7 single read");
      end
    end

    // R4: write burst in slave 2, words 4..11, with ignored inputs and a busy cycle
    cyc(mk(2, 4), 2'b10, 1'b1, 3'b001, pat(2, 4, 77), "R4 write burst open");
    for (int k = 5; k < 12; k++) begin
      if (k == 8) cyc(mk(2, 8), 2'b01, 1'b1, 3'b001, 32'hBAD0_0008, "R4 busy in burst");
      cyc(mk(2, k), 2'b11, (k % 2 == 0), (k % 3 == 0) ? 3'b000 : 3'b001,
          pat(2, k, 77), "R4 write burst beat, hwrite/hburst ignored");
    end
    cyc(mk(2, 12), 2'b00, 1'b1, 3'b001, 32'hBAD0_0012, "R5 idle closes burst");
    cyc(mk(2, 12), 2'b11, 1'b1, 3'b001, 32'hBAD1_0012, "R5 seq after close not served");
    cyc(mk(2, 12), 2'b00, 1'b0, 3'b000, 32'h0, "R5 idle");

    // R4 R7: read burst in slave 2, words 3..13, hwrite toggled on beats
    cyc(mk(2, 3), 2'b10, 1'b0, 3'b001, 32'h0, "R4 R7 read burst open");
    for (int k = 4; k < 14; k++) begin
      cyc(mk(2, k), 2'b11, (k % 2 == 1), 3'b000, 32'hBAD2_0000, "R4 R7 read burst beat");
    end
    cyc(mk(2, 0), 2'b00, 1'b0, 3'b000, 32'h0, "R5 idle closes read burst");

    // R8: idle, busy and stray sequential cycles outside a burst
    for (int s = 0; s < NS; s++) begin
      cyc(mk(s, 0), 2'b00, 1'b1, 3'b000, 32'hBAD3_0000, "R8 idle outside burst");
      cyc(mk(s, 1), 2'b01, 1'b1, 3'b001, 32'hBAD4_0000, "R8 busy outside burst");
      cyc(mk(s, 2), 2'b11, 1'b1, 3'b001, 32'hBAD5_0000, "R8 seq outside burst");
    end

    // R6 R7: read directly after write of the same word
    cyc(mk(3, 7), 2'b10, 1'b1, 3'b000, 32'h1234_5678, "R6 write");
    cyc(mk(3, 7), 2'b10, 0, 3'b000, 32'h0, "R6 R7 read after write");
    cyc(mk(0, 15), 2'b10, 1'b1, 3'b000, 32'h8765_4321, "R6 write");
    cyc(mk(0, 15), 2'b10, 1'b0, 3'b000, 32'h0, "R6 R7 read after write");

    // R1: reset in the middle of a write burst
    cyc(mk(1, 2), 2'b10, 1'b1, 3'b001, 32'h0BAD_C0DE ^ 32'h1, "R4 burst before reset");
    cyc(mk(1, 3), 2'b11, 1'b1, 3'b001, 32'h0BAD_C0DE ^ 32'h2, "R4 beat before reset");
    do_reset();
    cyc(mk(1, 4), 2'b11, 1'b1, 3'b001, 32'hBAD6_0000, "R1 burst cleared by reset");
    cyc(mk(1, 4), 2'b00, 1'b0, 3'b000, 32'h0, "R8 idle");

    // R8 R6: full read-back after all disturbing cycles
    for (int s = 0; s < NS; s++) begin
      for (int i = 0; i < WD; i++) begin
        cyc(mk(s, i), 2'b10, 1'b0, 3'b000, 32'h0, "R8 R6 contents kept");
      end
    end
    cyc(8'h00, 2'b00, 1'b0, 3'b000, 32'h0, "R8 final idle");
    cyc(8'h00, 2'b00, 1'b0, 3'b000, 32'h0, "R8 final idle");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule